// File: doc/BRIEF.md
# Time-of-Day Counter for Hardware Timestamping

This block keeps a running time of day as two fields: a seconds count and a sub-second count. It advances them from its own clock, which serves as the reference clock. In coarse mode the sub-second field grows by a programmable increment on every clock. In fine mode a 32-bit phase accumulator adds a programmable addend on every clock. The time then steps by the increment only on the cycles where the accumulator carries out. Software can trim the rate this way, for example to a nominal 20 ns tick at an effective 50 MHz.

The sub-second field wraps in one of two ways. With decimal rollover it counts nanoseconds and wraps at 10^9. With binary rollover it wraps at 2^31, so each count is about 0.465 ns. Every wrap carries into the seconds field, which itself wraps modulo 2^32.

Software works the block through a small register port. Three command bits in the control register are set by a write and clear themselves once the block has acted on them:
- load the time from the update registers;
- copy the addend register into the active accumulator addend;
- add an offset to the running time, or subtract one.

A subtraction is written in complement form, and the block performs a modular add with a carry or a borrow. Reading the current sub-second value also latches the seconds value. A following seconds read therefore belongs to the same instant.

A command sequencer with four states acts on the pending commands:
- ST_IDLE: waits for a pending command.
- ST_INIT: loads the time from the update registers.
- ST_ADJUST: applies the signed offset to the running time.
- ST_ADDEND: swaps in the new addend.

Transitions:
- From ST_IDLE it goes to ST_INIT when a time load is pending.
- Otherwise it goes to ST_ADJUST when an offset is pending.
- Otherwise it goes to ST_ADDEND when an addend copy is pending.
- Each action state lasts exactly one cycle. In that cycle it clears its command bit and returns to ST_IDLE.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds field, the sub-second field and the control register (address 0) all read as zero.
- R2: In coarse mode (control bit 0 = 0), the sub-second field grows by the increment register (address 1, 8 bits) on every clock.
- R3: With binary rollover (control bit 1 = 0), a sub-second sum of 2^31 or more wraps by subtracting 2^31 and adds one to the seconds field.
- R4: With decimal rollover (control bit 1 = 1), a sub-second sum of 10^9 or more wraps by subtracting 10^9 and adds one to the seconds field.
- R5: Writing 1 to control bit 2 loads seconds from address 3 and sub-seconds from bits 30:0 of address 4. The bit reads 1 for two cycles after the write and 0 from the third.
- R6: In fine mode (control bit 0 = 1), the time advances by the increment only on a cycle where the 32-bit accumulator carries out. With an addend of 2^31 it advances on exactly one of every two cycles.
- R7: A write to the addend register (address 2) changes the rate only after control bit 3 is written 1. That bit clears itself.
- R8: Writing 1 to control bit 4 with bit 31 of address 4 clear adds the update values (address 3, address 4 bits 30:0) to the time. The sub-second sum wraps at the selected modulus and carries into the seconds.
- R9: Writing 1 to control bit 4 with bit 31 of address 4 set treats the update values as complements. The result is seconds + update seconds, with a borrow of one when the sub-second sum stays below the modulus.
- R10: Reading the sub-second register (address 5) latches the seconds value. Reading address 6 returns that latched value, even if the seconds have moved on since.
- R11: The seconds field wraps from 2^32-1 to 0.
- R12: A new increment value written at a clock edge is used from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the time updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; data is valid after the next edge |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, held until the next read |

## Verification
A wrong sequencer state would show within two or three cycles. It would appear as a command bit that never clears on control readback, or as a time value that differs from the update registers right after a load. An accumulator or rollover fault would show within one or two reads. Fine-mode sub-second deltas would miss the exact half-rate step, or a wrap would leave the sub-second value off by the modulus or leave the seconds unchanged. A bad snapshot would show on the first seconds read taken after a wrap.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_ADDEND,
        ST_ADJUST
    } cmd_state_t;

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_INCR    = 3'd1;
    localparam logic [2:0] A_ADDEND  = 3'd2;
    localparam logic [2:0] A_UPD_SEC = 3'd3;
    localparam logic [2:0] A_UPD_SUB = 3'd4;
    localparam logic [2:0] A_NOW_SUB = 3'd5;
    localparam logic [2:0] A_NOW_SEC = 3'd6;

    localparam int C_FINE   = 0;
    localparam int C_DEC    = 1;
    localparam int C_INIT   = 2;
    localparam int C_ADDEND = 3;
    localparam int C_ADJUST = 4;
endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine,
    input  logic             load,
    input  logic [ACC_W-1:0] addend_in,
    output logic             tick
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] addend_act;
    logic [ACC_W:0]   sum;

    assign sum  = {1'b0, acc} + {1'b0, addend_act};
    assign tick = fine ? sum[ACC_W] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc        <= '0;
            addend_act <= '0;
        end else begin
            if (load) addend_act <= addend_in;
            if (fine) acc <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/tod_cmd_fsm.sv
module tod_cmd_fsm
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_init,
    input  logic pend_addend,
    input  logic pend_adjust,
    output logic do_init,
    output logic do_addend,
    output logic do_adjust
);
    cmd_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        if (state == ST_IDLE) begin
            if (pend_init)        state_nx = ST_INIT;
            else if (pend_adjust) state_nx = ST_ADJUST;
            else if (pend_addend) state_nx = ST_ADDEND;
        end
    end

    always_comb begin
        do_init   = 1'b0;
        do_addend = 1'b0;
        do_adjust = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_INIT:   do_init   = 1'b1;
            ST_ADDEND: do_addend = 1'b1;
            ST_ADJUST: do_adjust = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core #(
    parameter int          SEC_W   = 32,
    parameter int          SUB_W   = 31,
    parameter int          INC_W   = 8,
    parameter int unsigned DEC_MOD = 1000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec,
    input  logic             tick,
    input  logic [INC_W-1:0] incr,
    input  logic             do_init,
    input  logic             do_adjust,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W-1:0] upd_sub,
    input  logic             sub_neg,
    output logic [SEC_W-1:0] now_sec,
    output logic [SUB_W-1:0] now_sub
);
    localparam logic [SUB_W:0] BIN_M = {1'b1, {SUB_W{1'b0}}};
    localparam logic [SUB_W:0] DEC_M = (SUB_W+1)'(DEC_MOD);

    logic [SUB_W:0]   modulus;
    logic [SUB_W:0]   step_sum, adj_sum;
    logic             step_wrap, adj_carry;
    logic [SEC_W-1:0] sec_sum, adj_sec;

    assign modulus   = dec ? DEC_M : BIN_M;
    assign step_sum  = {1'b0, now_sub} + (SUB_W+1)'(incr);
    assign step_wrap = step_sum >= modulus;
    assign adj_sum   = {1'b0, now_sub} + {1'b0, upd_sub};
    assign adj_carry = adj_sum >= modulus;
    assign sec_sum   = now_sec + upd_sec;
    assign adj_sec   = sub_neg ? sec_sum - SEC_W'(!adj_carry)
                               : sec_sum + SEC_W'(adj_carry);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_sec <= '0;
            now_sub <= '0;
        end else if (do_init) begin
            now_sec <= upd_sec;
            now_sub <= upd_sub;
        end else if (do_adjust) begin
            now_sec <= adj_sec;
            now_sub <= adj_carry ? SUB_W'(adj_sum - modulus) : adj_sum[SUB_W-1:0];
        end else if (tick) begin
            if (step_wrap) begin
                now_sec <= now_sec + 1'b1;
                now_sub <= SUB_W'(step_sum - modulus);
            end else begin
                now_sub <= step_sum[SUB_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int          BUS_W   = 32,
    parameter int          ADDR_W  = 3,
    parameter int          SUB_W   = 31,
    parameter int          INC_W   = 8,
    parameter int          ACC_W   = 32,
    parameter int unsigned DEC_MOD = 1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int SEC_W = BUS_W;

    logic             fine_q, dec_q;
    logic             pend_init, pend_addend, pend_adjust;
    logic             do_init, do_addend, do_adjust;
    logic [INC_W-1:0] incr_q;
    logic [ACC_W-1:0] addend_q;
    logic [SEC_W-1:0] upd_sec_q, sec_snap;
    logic [BUS_W-1:0] upd_sub_q;
    logic [SEC_W-1:0] now_sec;
    logic [SUB_W-1:0] now_sub;
    logic             tick;
    logic             wr_ctrl;
    logic [BUS_W-1:0] rd_mux;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q      <= 1'b0;
            dec_q       <= 1'b0;
            pend_init   <= 1'b0;
            pend_addend <= 1'b0;
            pend_adjust <= 1'b0;
            incr_q      <= '0;
            addend_q    <= '0;
            upd_sec_q   <= '0;
            upd_sub_q   <= '0;
        end else begin
            pend_init   <= (pend_init   & ~do_init)   | (wr_ctrl & wr_data[C_INIT]);
            pend_addend <= (pend_addend & ~do_addend) | (wr_ctrl & wr_data[C_ADDEND]);
            pend_adjust <= (pend_adjust & ~do_adjust) | (wr_ctrl & wr_data[C_ADJUST]);
            if (wr_ctrl) begin
                fine_q <= wr_data[C_FINE];
                dec_q  <= wr_data[C_DEC];
            end
            if (wr_en) begin
                unique case (wr_addr)
                    ADDR_W'(A_INCR):    incr_q    <= wr_data[INC_W-1:0];
                    ADDR_W'(A_ADDEND):  addend_q  <= wr_data[ACC_W-1:0];
                    ADDR_W'(A_UPD_SEC): upd_sec_q <= wr_data;
                    ADDR_W'(A_UPD_SUB): upd_sub_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (rd_addr)
            ADDR_W'(A_CTRL): begin
                rd_mux[C_FINE]   = fine_q;
                rd_mux[C_DEC]    = dec_q;
                rd_mux[C_INIT]   = pend_init;
                rd_mux[C_ADDEND] = pend_addend;
                rd_mux[C_ADJUST] = pend_adjust;
            end
            ADDR_W'(A_INCR):    rd_mux = BUS_W'(incr_q);
            ADDR_W'(A_ADDEND):  rd_mux = BUS_W'(addend_q);
            ADDR_W'(A_UPD_SEC): rd_mux = upd_sec_q;
            ADDR_W'(A_UPD_SUB): rd_mux = upd_sub_q;
            ADDR_W'(A_NOW_SUB): rd_mux = BUS_W'(now_sub);
            ADDR_W'(A_NOW_SEC): rd_mux = sec_snap;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            sec_snap <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
            if (rd_addr == ADDR_W'(A_NOW_SUB)) sec_snap <= now_sec;
        end
    end

    tod_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_init   (pend_init),
        .pend_addend (pend_addend),
        .pend_adjust (pend_adjust),
        .do_init     (do_init),
        .do_addend   (do_addend),
        .do_adjust   (do_adjust)
    );

    tod_tick_gen #(.ACC_W(ACC_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .fine      (fine_q),
        .load      (do_addend),
        .addend_in (addend_q),
        .tick      (tick)
    );

    tod_time_core #(
        .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .DEC_MOD(DEC_MOD)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec_q),
        .tick      (tick),
        .incr      (incr_q),
        .do_init   (do_init),
        .do_adjust (do_adjust),
        .upd_sec   (upd_sec_q),
        .upd_sub   (upd_sub_q[SUB_W-1:0]),
        .sub_neg   (upd_sub_q[BUS_W-1]),
        .now_sec   (now_sec),
        .now_sub   (now_sub)
    );
endmodule

// File: rtl/tod_checker.sv
module tod_checker #(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 31,
    parameter int INC_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fine_q,
    input logic              dec_q,
    input logic              tick,
    input logic              do_init,
    input logic              do_addend,
    input logic              do_adjust,
    input logic              pend_init,
    input logic [INC_W-1:0]  incr_q,
    input logic [SEC_W-1:0]  upd_sec_q,
    input logic [SEC_W-1:0]  upd_sub_q,
    input logic [SEC_W-1:0]  now_sec,
    input logic [SUB_W-1:0]  now_sub,
    input logic [SEC_W-1:0]  sec_snap,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr
);
    logic [SUB_W:0] bin_next;
    assign bin_next = {1'b0, now_sub} + (SUB_W+1)'(incr_q);

    p_init_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> (now_sec == $past(upd_sec_q)) && (now_sub == $past(upd_sub_q[SUB_W-1:0])));

    p_init_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> !pend_init);

    p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_init, do_addend, do_adjust}));

    p_coarse_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fine_q && !dec_q && !do_init && !do_adjust && !bin_next[SUB_W])
        |=> now_sub == $past(bin_next[SUB_W-1:0]));

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_init && !do_adjust)
        |=> (now_sec == $past(now_sec)) || (now_sec == $past(now_sec) + 1'b1));

    p_fine_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_q && !tick && !do_init && !do_adjust) |=> $stable(now_sub));

    p_snapshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(5)) |=> sec_snap == $past(now_sec));
endmodule

bind tod_counter tod_checker #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fine_q    (fine_q),
    .dec_q     (dec_q),
    .tick      (tick),
    .do_init   (do_init),
    .do_addend (do_addend),
    .do_adjust (do_adjust),
    .pend_init (pend_init),
    .incr_q    (incr_q),
    .upd_sec_q (upd_sec_q),
    .upd_sub_q (upd_sub_q),
    .now_sec   (now_sec),
    .now_sub   (now_sub),
    .sec_snap  (sec_snap),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;
    localparam logic [2:0] CTRL = 3'd0, INCR = 3'd1, ADDEND = 3'd2,
                           USEC = 3'd3, USUB = 3'd4, NSUB = 3'd5, NSEC = 3'd6;
    localparam logic [31:0] NEG  = 32'h8000_0000;
    localparam logic [31:0] GIGA = 32'd1_000_000_000;

    typedef struct packed {
        logic [31:0] dec, s0, n0, us, un, es, en;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{32'd0, 32'd100, 32'd1000, 32'd2, 32'd500, 32'd102, 32'd1500},
        '{32'd0, 32'd100, 32'h7FFF_FF00, 32'd2, 32'h200, 32'd103, 32'h100},
        '{32'd1, 32'd100, 32'd900_000_000, 32'd2, 32'd200_000_000, 32'd103, 32'd100_000_000},
        '{32'd1, 32'd100, 32'd500, 32'hFFFF_FFFD, NEG | (GIGA - 32'd200), 32'd97, 32'd300},
        '{32'd1, 32'd100, 32'd100, 32'd0, NEG | (GIGA - 32'd200), 32'd99, 32'd999_999_900},
        '{32'd0, 32'd100, 32'd10, 32'hFFFF_FFFF, NEG | (32'h8000_0000 - 32'd20), 32'd98, 32'h7FFF_FFF6},
        '{32'd1, 32'hFFFF_FFFF, 32'd0, 32'd1, 32'd0, 32'd0, 32'd0}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic poll();
        logic [31:0] v;
        for (int k = 0; k < 20; k++) begin
            rd(CTRL, v);
            if (v[4:2] == 3'b000) return;
        end
        check("R5 command bits clear", v & 32'h1C, 32'h0);
    endtask

    task automatic set_time(input logic dec, input logic [31:0] s, input logic [31:0] n);
        wr(CTRL, {30'd0, dec, 1'b0});
        wr(USEC, s);
        wr(USUB, n);
        wr(CTRL, {27'd0, 3'b001, dec, 1'b0});
        poll();
    endtask

    task automatic one_tick(input logic [31:0] n);
        wr(INCR, n);
        wr(INCR, 32'd0);
    endtask

    initial begin
        #500000.0;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, r0, r1, r2, r3, r4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(NSUB, v); check("R1 sub-second", v, 32'd0);
        rd(NSEC, v); check("R1 seconds", v, 32'd0);
        rd(CTRL, v); check("R1 control", v, 32'd0);

        // R8 R9 R11 offset vectors, time frozen with increment 0
        for (int i = 0; i < 7; i++) begin
            set_time(VEC[i].dec[0], VEC[i].s0, VEC[i].n0);
            wr(USEC, VEC[i].us);
            wr(USUB, VEC[i].un);
            wr(CTRL, {27'd0, 3'b100, VEC[i].dec[0], 1'b0});
            poll();
            rd(NSUB, v); check($sformatf("R8 R9 R11 vector %0d sub", i), v, VEC[i].en);
            rd(NSEC, v); check($sformatf("R8 R9 R11 vector %0d sec", i), v, VEC[i].es);
        end

        // R5 load command and its self-clearing timing
        wr(CTRL, 32'd0);
        wr(USEC, 32'd77);
        wr(USUB, 32'd12345);
        wr(CTRL, 32'h4);
        rd(CTRL, v); check("R5 bit set one cycle after write", {31'd0, v[2]}, 32'd1);
        rd(CTRL, v);
        rd(CTRL, v); check("R5 bit clear third cycle", {31'd0, v[2]}, 32'd0);
        rd(NSUB, v); check("R5 loaded sub", v, 32'd12345);
        rd(NSEC, v); check("R5 loaded sec", v, 32'd77);

        // R12 R2 increment takes effect next edge, then every clock
        wr(INCR, 32'd7);
        rd(NSUB, v); check("R12 no step on write edge", v, 32'd12345);
        rd(NSUB, v); check("R2 R12 first step", v, 32'd12352);
        rd(NSUB, v); check("R2 second step", v, 32'd12359);
        wr(INCR, 32'd0);

        // R3 binary wrap
        set_time(1'b0, 32'd9, 32'h7FFF_FFFE);
        one_tick(32'd3);
        rd(NSUB, v); check("R3 binary wrap sub", v, 32'd1);
        rd(NSEC, v); check("R3 binary wrap sec", v, 32'd10);

        // R4 decimal wrap
        set_time(1'b1, 32'd9, 32'd999_999_999);
        one_tick(32'd3);
        rd(NSUB, v); check("R4 decimal wrap sub", v, 32'd2);
        rd(NSEC, v); check("R4 decimal wrap sec", v, 32'd10);

        // R11 seconds wrap from a tick carry
        set_time(1'b1, 32'hFFFF_FFFF, 32'd999_999_999);
        one_tick(32'd1);
        rd(NSUB, v); check("R11 wrap sub", v, 32'd0);
        rd(NSEC, v); check("R11 wrap sec", v, 32'd0);

        // R10 snapshot coherence across a wrap
        set_time(1'b1, 32'd5, 32'd999_999_990);
        wr(INCR, 32'd1);
        rd(NSUB, v); check("R10 sub before wrap", v, 32'd999_999_990);
        repeat (20) @(negedge clk);
        rd(NSEC, v); check("R10 snapshot holds", v, 32'd5);
        rd(NSUB, v);
        rd(NSEC, v); check("R10 new snapshot", v, 32'd6);
        wr(INCR, 32'd0);

        // R6 fine mode with addend 2^31
        set_time(1'b0, 32'd0, 32'd0);
        wr(ADDEND, 32'h8000_0000);
        wr(CTRL, 32'h9);
        poll();
        wr(INCR, 32'd10);
        rd(NSUB, r0); rd(NSUB, r1); rd(NSUB, r2); rd(NSUB, r3); rd(NSUB, r4);
        check("R6 two cycles one step", r2 - r0, 32'd10);
        check("R6 four cycles two steps", r4 - r0, 32'd20);

        // R7 addend write alone has no effect until the copy command
        wr(ADDEND, 32'd0);
        rd(NSUB, r0); rd(NSUB, r1); rd(NSUB, r2);
        check("R7 old addend still active", r2 - r0, 32'd10);
        wr(CTRL, 32'h9);
        poll();
        rd(NSUB, r0); rd(NSUB, r1); rd(NSUB, r2);
        check("R7 new addend stops time", r2 - r0, 32'd0);
        wr(CTRL, 32'd0);
        wr(INCR, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule